// File: doc/BRIEF.md
# Parallel-Issue Multiply-Accumulate Audio Datapath

This block is the arithmetic core of an audio delay-line processor. A sequencer outside the block presents one 18-bit instruction word and one 16-bit coefficient on every clock. Five operation fields in that word run together in a single cycle:

- a multiply of a selected operand by the coefficient;
- an add into a 22-bit accumulator;
- a read from or write to external delay memory;
- a copy of the accumulator into one of two delay-data registers;
- a copy of the input register into a holding register.

The product is registered, so the add of the next instruction consumes it. This lets a multiply and an accumulate of consecutive taps overlap.

All data are two's-complement Q1.15 fractions. The multiply saturates, so that minus one times minus one gives the largest positive value and does not wrap. The accumulator keeps headroom above 16 bits. Wherever the accumulator leaves the block as a 16-bit value, it passes through a clamp to the 16-bit range. This applies when it is a multiplicand, when it is written to memory, and when it is transferred. Every register update in a cycle uses the values the registers held at the start of that cycle. Address generation, sequencing and coefficient storage lie outside the block.

Top module: `pmac_datapath`

## Requirements
- R1: Instruction bits 11:10 pick the multiplicand: 00 the right delay register, 01 the clamped accumulator, 10 the left delay register, 11 the input register.
- R2: The product register takes the full signed product shifted right by 15 with floor rounding. A result of +1.0 (only from 0x8000 times 0x8000) saturates to 0x7FFF.
- R3: The product of one instruction enters the accumulator at the add of the following instruction, not the add of its own.
- R4: When the accumulator serves as a 16-bit value (multiplicand, memory data, transfer), values above 0x7FFF give 0x7FFF and values below -0x8000 give 0x8000. The full 22-bit value stays in the accumulator.
- R5: Instruction bits 15:14 pick the augend: 00 zero, 01 the holding register (sign-extended), 10 the accumulator, 11 the left delay register (sign-extended). The sum with the sign-extended product is written to the accumulator every cycle.
- R6: With bit 17 high, the input register loads mem_rdata, mem_wr is 0 and mem_wdata is 0.
- R7: With bit 17 low, mem_wr is 1 and the input register holds. mem_wdata shows the right delay register when bits 13:12 are 11, and the clamped accumulator for any other code.
- R8: Bits 13:12 set to 01 copy the clamped accumulator into the left delay register. Set to 10, they copy it into the right delay register. Codes 00 and 11 leave both delay registers unchanged.
- R9: With bit 16 low, the holding register takes the input register's value from the start of the cycle. With bit 16 high, it holds.
- R10: A synchronous active-low reset clears every register to zero and overrides any presented instruction.
- R11: Instruction bits 9:0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| instr | input | 18 | Instruction word for this cycle |
| coef | input | 16 | Q1.15 multiplication coefficient |
| mem_rdata | input | 16 | Data returned by delay memory |
| mem_wr | output | 1 | High when this cycle writes delay memory |
| mem_wdata | output | 16 | Data to delay memory, zero in read cycles |

## Verification
The bench builds the block with its default widths: 16-bit data, a 22-bit accumulator and an 18-bit instruction. With these widths, the clamp and the multiply overflow can be reached within a handful of instructions. Two products of 0x7FFF lift the accumulator to 0xFFFE, and a negative pair drives it below -0x8000. Both limits of the 16-bit view can therefore be observed at the memory data port, together with the one-step product delay and the same-cycle ordering of register copies.

// File: rtl/pmac_pkg.sv
`timescale 1ns/1ps
// pmac_pkg: shared widths, instruction field positions and decoded
// control types for the parallel multiply-accumulate datapath.
package pmac_pkg;

    localparam int DATA_W   = 16;
    localparam int ACC_W    = 22;
    localparam int INSTR_W  = 18;

    // Field positions inside the instruction word
    localparam int MSEL_LSB = 10;
    localparam int XFER_LSB = 12;
    localparam int ASEL_LSB = 14;
    localparam int HOLD_BIT = 16;
    localparam int RD_BIT   = 17;

    typedef enum logic [1:0] {
        MUL_DAR = 2'b00,
        MUL_ACC = 2'b01,
        MUL_DAL = 2'b10,
        MUL_R1  = 2'b11
    } mul_src_e;

    typedef enum logic [1:0] {
        ADD_ZERO = 2'b00,
        ADD_R2   = 2'b01,
        ADD_ACC  = 2'b10,
        ADD_DAL  = 2'b11
    } add_src_e;

    typedef enum logic [1:0] {
        XF_NONE   = 2'b00,
        XF_TO_DAL = 2'b01,
        XF_TO_DAR = 2'b10,
        XF_OUTDAR = 2'b11
    } xfer_e;

    typedef struct packed {
        logic     rd;
        logic     hold_r2;
        add_src_e asrc;
        xfer_e    xf;
        mul_src_e msrc;
    } pmac_ctl_t;

endpackage

// File: rtl/pmac_decode.sv
`timescale 1ns/1ps
// pmac_decode: splits the instruction word into its independent fields.
// Assumes fixed field positions from pmac_pkg; bits below MSEL_LSB are
// unused and deliberately ignored.
module pmac_decode
    import pmac_pkg::*;
#(
    parameter int IW = INSTR_W
) (
    input  logic [IW-1:0] instr,
    output pmac_ctl_t     ctl
);

    logic unused_low;

    // Field extraction; every field is decoded in parallel
    always_comb begin
        ctl.rd      = instr[RD_BIT];
        ctl.hold_r2 = instr[HOLD_BIT];
        ctl.asrc    = add_src_e'(instr[ASEL_LSB +: 2]);
        ctl.xf      = xfer_e'(instr[XFER_LSB +: 2]);
        ctl.msrc    = mul_src_e'(instr[MSEL_LSB +: 2]);
    end

    // Collects the ignored low bits so they are visibly consumed
    assign unused_low = ^instr[MSEL_LSB-1:0];

endmodule

// File: rtl/pmac_regs.sv
`timescale 1ns/1ps
// pmac_regs: input register, holding register and the two delay-data
// registers. All updates use start-of-cycle values, so a read into the
// input register and a copy to the holding register in the same cycle
// move the old input value. Reset is synchronous, active low.
module pmac_regs
    import pmac_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  pmac_ctl_t     ctl,
    input  logic [DW-1:0] mem_rdata,
    input  logic [DW-1:0] acc_sat,
    output logic [DW-1:0] r1_q,
    output logic [DW-1:0] r2_q,
    output logic [DW-1:0] dal_q,
    output logic [DW-1:0] dar_q
);

    // Input register: loads memory data only in read cycles
    always_ff @(posedge clk) begin
        if (!rst_n)      r1_q <= '0;
        else if (ctl.rd) r1_q <= mem_rdata;
    end

    // Holding register: copies the input register when the hold bit is low
    always_ff @(posedge clk) begin
        if (!rst_n)            r2_q <= '0;
        else if (!ctl.hold_r2) r2_q <= r1_q;
    end

    // Left delay register: takes the clamped accumulator on code 01
    always_ff @(posedge clk) begin
        if (!rst_n)                  dal_q <= '0;
        else if (ctl.xf == XF_TO_DAL) dal_q <= acc_sat;
    end

    // Right delay register: takes the clamped accumulator on code 10
    always_ff @(posedge clk) begin
        if (!rst_n)                  dar_q <= '0;
        else if (ctl.xf == XF_TO_DAR) dar_q <= acc_sat;
    end

endmodule

// File: rtl/pmac_mul.sv
`timescale 1ns/1ps
// pmac_mul: selects the multiplicand, forms the signed Q1.15 product with
// floor rounding and saturation, and registers it for use by the add of
// the next instruction. The only overflow is +1.0, clamped to max positive.
module pmac_mul
    import pmac_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  mul_src_e      msrc,
    input  logic [DW-1:0] r1_q,
    input  logic [DW-1:0] dal_q,
    input  logic [DW-1:0] dar_q,
    input  logic [DW-1:0] acc_sat,
    input  logic [DW-1:0] coef,
    output logic [DW-1:0] prod_q
);

    localparam int FW = 2 * DW;
    localparam logic [DW-1:0] POS_MAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] NEG_MAX = {1'b1, {(DW-1){1'b0}}};

    logic [DW-1:0]        opnd;
    logic signed [FW-1:0] full;
    logic [DW-1:0]        prod_d;

    // Multiplicand selection from the four sources
    always_comb begin
        unique case (msrc)
            MUL_DAR: opnd = dar_q;
            MUL_ACC: opnd = acc_sat;
            MUL_DAL: opnd = dal_q;
            default: opnd = r1_q;
        endcase
    end

    // Full-precision signed product
    assign full = $signed(opnd) * $signed(coef);

    // Realign to Q1.15; the two top bits differ only on overflow
    always_comb begin
        if (full[FW-1] != full[FW-2])
            prod_d = full[FW-1] ? NEG_MAX : POS_MAX;
        else
            prod_d = full[FW-2:DW-1];
    end

    // Product pipeline register
    always_ff @(posedge clk) begin
        if (!rst_n) prod_q <= '0;
        else        prod_q <= prod_d;
    end

endmodule

// File: rtl/pmac_acc.sv
`timescale 1ns/1ps
// pmac_acc: augend selection, 22-bit add of the previous product and the
// accumulator register, plus the clamped 16-bit view of the accumulator.
// Assumes the accumulator is wider than the data path.
module pmac_acc
    import pmac_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ACC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  add_src_e      asrc,
    input  logic [DW-1:0] r2_q,
    input  logic [DW-1:0] dal_q,
    input  logic [DW-1:0] prod_q,
    output logic [AW-1:0] acc_q,
    output logic [DW-1:0] acc_sat
);

    localparam int EXT = AW - DW;
    localparam logic [DW-1:0] POS_MAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] NEG_MAX = {1'b1, {(DW-1){1'b0}}};

    logic [AW-1:0] augend;
    logic [AW-1:0] prod_ext;
    logic [EXT:0]  top_bits;

    // Augend selection with sign extension of the 16-bit sources
    always_comb begin
        unique case (asrc)
            ADD_ZERO: augend = '0;
            ADD_R2:   augend = {{EXT{r2_q[DW-1]}}, r2_q};
            ADD_ACC:  augend = acc_q;
            default:  augend = {{EXT{dal_q[DW-1]}}, dal_q};
        endcase
    end

    // Sign-extended product from the previous instruction
    assign prod_ext = {{EXT{prod_q[DW-1]}}, prod_q};

    // Accumulator register: written every cycle with augend plus product
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= augend + prod_ext;
    end

    // Clamp to the 16-bit range when the upper bits are not a sign extension
    assign top_bits = acc_q[AW-1:DW-1];
    always_comb begin
        if ((top_bits == '0) || (top_bits == '1))
            acc_sat = acc_q[DW-1:0];
        else
            acc_sat = acc_q[AW-1] ? NEG_MAX : POS_MAX;
    end

endmodule

// File: rtl/pmac_datapath.sv
`timescale 1ns/1ps
// pmac_datapath: top of the parallel-issue multiply-accumulate datapath.
// Decodes one instruction per clock and runs multiply, add, memory
// access, accumulator transfer and register transfer together.
// Assumes the instruction and coefficient are valid every cycle.
module pmac_datapath
    import pmac_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ACC_W,
    parameter int IW = INSTR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] instr,
    input  logic [DW-1:0] coef,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata
);

    pmac_ctl_t     ctl;
    logic [DW-1:0] r1_q;
    logic [DW-1:0] r2_q;
    logic [DW-1:0] dal_q;
    logic [DW-1:0] dar_q;
    logic [DW-1:0] prod_q;
    logic [AW-1:0] acc_q;
    logic [DW-1:0] acc_sat;

    pmac_decode #(.IW(IW)) u_dec (
        .instr (instr),
        .ctl   (ctl)
    );

    pmac_regs #(.DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .acc_sat   (acc_sat),
        .r1_q      (r1_q),
        .r2_q      (r2_q),
        .dal_q     (dal_q),
        .dar_q     (dar_q)
    );

    pmac_mul #(.DW(DW)) u_mul (
        .clk     (clk),
        .rst_n   (rst_n),
        .msrc    (ctl.msrc),
        .r1_q    (r1_q),
        .dal_q   (dal_q),
        .dar_q   (dar_q),
        .acc_sat (acc_sat),
        .coef    (coef),
        .prod_q  (prod_q)
    );

    pmac_acc #(.DW(DW), .AW(AW)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .asrc    (ctl.asrc),
        .r2_q    (r2_q),
        .dal_q   (dal_q),
        .prod_q  (prod_q),
        .acc_q   (acc_q),
        .acc_sat (acc_sat)
    );

    // Memory port: write flag and write data, zero data during reads
    always_comb begin
        mem_wr = !ctl.rd;
        if (ctl.rd)                  mem_wdata = '0;
        else if (ctl.xf == XF_OUTDAR) mem_wdata = dar_q;
        else                         mem_wdata = acc_sat;
    end

endmodule

// File: rtl/pmac_checker.sv
`timescale 1ns/1ps
// pmac_checker: temporal properties of the datapath, bound to the top.
module pmac_checker #(
    parameter int DW = 16,
    parameter int AW = 22,
    parameter int IW = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic [IW-1:0] instr,
    input logic [DW-1:0] mem_rdata,
    input logic [DW-1:0] mem_wdata,
    input logic [DW-1:0] r1_q,
    input logic [DW-1:0] r2_q,
    input logic [DW-1:0] dal_q,
    input logic [DW-1:0] dar_q,
    input logic [DW-1:0] prod_q,
    input logic [AW-1:0] acc_q
);

    // R6: read cycle captures memory data in the input register
    p_read_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        instr[17] |=> r1_q == $past(mem_rdata));

    // R7: write cycle leaves the input register unchanged
    p_write_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !instr[17] |=> $stable(r1_q));

    // R9: copy takes the start-of-cycle input value, or holds
    p_r2_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !instr[16] |=> r2_q == $past(r1_q));
    p_r2_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        instr[16] |=> $stable(r2_q));

    // R8: delay registers change only on their own transfer code
    p_dal_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[13:12] != 2'b01) |=> $stable(dal_q));
    p_dar_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[13:12] != 2'b10) |=> $stable(dar_q));
    p_dal_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!instr[17] && instr[13:12] == 2'b01) |=> dal_q == $past(mem_wdata));

    // R3, R5: zero augend leaves exactly the previous product in the accumulator
    p_zero_aug_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[15:14] == 2'b00) |=>
        acc_q == {{(AW-DW){$past(prod_q[DW-1])}}, $past(prod_q)});

    // R2: the most negative code is unreachable for a saturated product
    p_prod_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        prod_q != {1'b1, {(DW-1){1'b0}}});

    // R10: reset clears the state on the following cycle
    p_reset_clear_r10: assert property (@(posedge clk)
        !rst_n |=> (acc_q == '0 && prod_q == '0 && r1_q == '0 &&
                    r2_q == '0 && dal_q == '0 && dar_q == '0));

endmodule

bind pmac_datapath pmac_checker #(.DW(DW), .AW(AW), .IW(IW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .instr     (instr),
    .mem_rdata (mem_rdata),
    .mem_wdata (mem_wdata),
    .r1_q      (r1_q),
    .r2_q      (r2_q),
    .dal_q     (dal_q),
    .dar_q     (dar_q),
    .prod_q    (prod_q),
    .acc_q     (acc_q)
);

// File: tb/pmac_datapath_test.sv
`timescale 1ns/1ps
// Bench: vector table walked by one loop, then directed reset checks.
// Opcode byte = {rd, hold, asel[1:0], xfer[1:0], msel[1:0]}.
module pmac_datapath_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [17:0] instr = '0;
    logic [15:0] coef = '0;
    logic [15:0] mem_rdata = '0;
    logic        mem_wr;
    logic [15:0] mem_wdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pmac_datapath uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .instr     (instr),
        .coef      (coef),
        .mem_rdata (mem_rdata),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata)
    );

    typedef struct packed {
        logic [7:0]  op;
        logic [15:0] k;
        logic [15:0] din;
        logic        wr;
        logic [15:0] wd;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VEC [NV] = '{
        '{8'hC3, 16'h0000, 16'h4000, 1'b0, 16'h0000, 4'd6},  // R6 read, zero data
        '{8'h83, 16'h4000, 16'h1234, 1'b0, 16'h0000, 4'd6},  // R6 read + R9 copy
        '{8'h43, 16'h0000, 16'h5555, 1'b1, 16'h0000, 4'd3},  // R3 product not yet added
        '{8'h52, 16'h0000, 16'h5555, 1'b1, 16'h2000, 4'd3},  // R3 product arrives
        '{8'h64, 16'h0000, 16'h5555, 1'b1, 16'h4000, 4'd9},  // R9 holding got old input
        '{8'h7A, 16'h8000, 16'h5555, 1'b1, 16'h4000, 4'd5},  // R5 acc augend
        '{8'h6C, 16'h8000, 16'h5555, 1'b1, 16'h4000, 4'd8},  // R8 DAR copy, R7 DAR out
        '{8'h40, 16'h0000, 16'h5555, 1'b1, 16'h0000, 4'd5},  // R5 DAL augend + P
        '{8'h60, 16'h0000, 16'h5555, 1'b1, 16'hC000, 4'd1},  // R1 DAR multiplicand
        '{8'hE3, 16'h0000, 16'h8000, 1'b0, 16'h0000, 4'd6},  // R6 load -1
        '{8'h43, 16'h8000, 16'h5555, 1'b1, 16'hC000, 4'd7},  // R7 write keeps input
        '{8'h43, 16'h0000, 16'h5555, 1'b1, 16'h0000, 4'd2},  // R2 zero augend
        '{8'h63, 16'h8000, 16'h5555, 1'b1, 16'h7FFF, 4'd2},  // R2 -1 x -1 saturated
        '{8'h63, 16'h0000, 16'h5555, 1'b1, 16'h7FFF, 4'd5},  // R5 accumulate
        '{8'h61, 16'h7FFF, 16'h5555, 1'b1, 16'h7FFF, 4'd4},  // R4 clamp 0xFFFE
        '{8'h40, 16'h0000, 16'h5555, 1'b1, 16'h7FFF, 4'd4},  // R4 wide value kept
        '{8'h43, 16'h7FFF, 16'h5555, 1'b1, 16'h7FFE, 4'd4},  // R4 clamped multiplicand
        '{8'h63, 16'h7FFF, 16'h5555, 1'b1, 16'h0000, 4'd1},  // R1 input multiplicand
        '{8'h63, 16'h0000, 16'h5555, 1'b1, 16'h8001, 4'd1},  // R1 product floor
        '{8'h65, 16'h4000, 16'h5555, 1'b1, 16'h8000, 4'd4},  // R4 negative clamp
        '{8'h40, 16'h0000, 16'h5555, 1'b1, 16'h8000, 4'd4},  // R4 acc stays wide
        '{8'h70, 16'h0000, 16'h5555, 1'b1, 16'hC000, 4'd4},  // R4 clamped multiply
        '{8'h60, 16'h0000, 16'h5555, 1'b1, 16'h8000, 4'd5},  // R5 DAL sign-extended
        '{8'h6C, 16'h0000, 16'h5555, 1'b1, 16'h4000, 4'd8}   // R8 DAR kept
    };

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // Drive one opcode at the falling edge; sample 1 ns later
    task automatic step(input logic [7:0] op, input logic [15:0] k,
                        input logic [15:0] din, input logic [9:0] low);
        @(negedge clk);
        instr     = {op, low};
        coef      = k;
        mem_rdata = din;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: output during reset shows a cleared accumulator
        instr = {8'h60, 10'h0};
        #1;
        check("R10 reset acc", mem_wdata, 16'h0000);
        rst_n = 1'b1;

        // Vector walk; R11: low bits carry a changing pattern
        for (int i = 0; i < NV; i++) begin
            step(VEC[i].op, VEC[i].k, VEC[i].din, 10'(i * 37 + 5));
            check($sformatf("R%0d vec%0d wr", VEC[i].req, i), {15'd0, mem_wr}, {15'd0, VEC[i].wr});
            check($sformatf("R%0d vec%0d data", VEC[i].req, i), mem_wdata, VEC[i].wd);
        end

        // R11: same opcode with all-ones low bits matches the zero-bit result
        step(8'h6C, 16'h0000, 16'h5555, 10'h3FF);
        check("R11 low bits ignored", mem_wdata, 16'h4000);

        // R10: reset overrides an active instruction
        @(negedge clk);
        rst_n = 1'b0;
        instr = {8'h8F, 10'h0};
        coef  = 16'h8000;
        mem_rdata = 16'h7777;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        instr = {8'h6C, 10'h0};
        coef  = 16'h0000;
        #1;
        check("R10 DAR cleared", mem_wdata, 16'h0000);
        step(8'h43, 16'h7FFF, 16'h0000, 10'h0);
        check("R10 acc cleared", mem_wdata, 16'h0000);
        step(8'h70, 16'h0000, 16'h0000, 10'h0);
        check("R10 input cleared", mem_wdata, 16'h0000);
        step(8'h60, 16'h0000, 16'h0000, 10'h0);
        check("R10 DAL cleared", mem_wdata, 16'h0000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule